// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block sits between a set of peripheral interrupt request lines and a small CPU sequencer. Each request line sets a sticky pending flag. The flag stays set until the CPU acknowledges entry into that request's handler. Each flag is gated by its own enable bit and by a global mask bit. Arbitration happens only at an instruction boundary: when the sequencer reports that an instruction has finished, or when a return-from-interrupt completes. At that point the block picks one winner, latches it, and presents a fixed vector identifier. The CPU uses that identifier to choose which vector to fetch.

A software interrupt instruction is reported together with its completion strobe. It is taken whatever the mask, and it outranks every hardware request. When the CPU acknowledges entry, the block saves the current mask, sets the mask, and clears the winner's pending flag. Return-from-interrupt restores the saved mask and arbitrates in that same cycle, so a request that is still pending is taken before the next program instruction runs.

Top module: `irq_boundary_arb`

## Requirements
- R1: The block latches a new winner only in a cycle where `instr_done` or `rti_stb` is high. Pending requests alone, with no boundary strobe, never raise `win_valid`.
- R2: A hardware request takes part in arbitration only when its bit in `irq_en` is 1 and the effective mask is 0. If no request is eligible, the boundary passes with `win_valid` staying low.
- R3: Among eligible requests, the lowest index wins. `win_vec` equals the winning index (0 to NUM_IRQ-1).
- R4: When `swi_req` is high together with `instr_done`, the block latches `win_vec` = NUM_IRQ (8 by default). It does so regardless of the mask and ahead of any pending hardware request.
- R5: Once `win_valid` is high, `win_vec` holds and later requests cannot displace it until `entry_ack` arrives. The one exception: a `mask_clr` strobe while a hardware winner waits discards that winner, so that the next boundary re-arbitrates.
- R6: `entry_ack` while `win_valid` is high has four effects on the next cycle. It saves the current mask, sets `mask_bit`, clears the pending flag of a hardware winner only (other flags are kept), and drops `win_valid`.
- R7: `rti_stb` restores the saved mask on the next cycle. Arbitration in that same cycle uses the restored value, so an eligible pending request is latched immediately.
- R8: A one-cycle pulse on `irq_req[i]` sets `pending[i]`, which stays 1 until the entry of that index is acknowledged.
- R9: After reset, `mask_bit` is 1, `pending` is all zero and `win_valid` is 0.
- R10: `mask_set` and `mask_clr` strobes change `mask_bit` on the following cycle. Entry, then return, then set, then clear take precedence in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Request pulses or levels, one per source |
| irq_en | input | NUM_IRQ | Per-source enable bits |
| instr_done | input | 1 | Current instruction has completed (boundary) |
| swi_req | input | 1 | The completing instruction is a software interrupt |
| entry_ack | input | 1 | CPU has begun entry into the latched handler |
| rti_stb | input | 1 | Return-from-interrupt has completed |
| mask_set | input | 1 | Set the global mask |
| mask_clr | input | 1 | Clear the global mask |
| win_valid | output | 1 | A winner is latched and awaits entry |
| win_vec | output | VEC_W | Vector identifier of the latched winner |
| mask_bit | output | 1 | Current global mask bit |
| pending | output | NUM_IRQ | Pending flags |

## Verification
The assertions take for granted that the sequencer behaves as a CPU would. It raises `entry_ack` only while a winner is shown. It never raises `rti_stb` in the same cycle as `entry_ack` or `instr_done`. It reports `swi_req` only together with `instr_done`. The directed tasks drive each strobe for exactly one cycle, at the falling edge, and follow this order of events. Every handler entry is closed by its return before a new boundary is given, except in the scenario that deliberately leaves a winner waiting in order to test displacement and the mask-clear discard.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_HW   = 2'd1,
    WSRC_SWI  = 2'd2
  } win_src_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req,
  input  logic               clr_stb,
  input  logic [VEC_W-1:0]   clr_idx,
  output logic [NUM_IRQ-1:0] pend_q
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_stb && (clr_idx == VEC_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[g] <= 1'b0;
      else if (req[g])     pend_q[g] <= 1'b1;
      else if (clr_hit)    pend_q[g] <= 1'b0;
    end
    // a cleared flag only falls on an acknowledge for its own index
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] && !clr_hit |=> pend_q[g]); // R8
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic               mask_eff,
  output logic               any,
  output logic [VEC_W-1:0]   idx
);
  logic [NUM_IRQ-1:0] elig;

  function automatic logic [VEC_W-1:0] lowest_set(input logic [NUM_IRQ-1:0] v);
    lowest_set = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (v[i]) lowest_set = VEC_W'(i);
  endfunction

  assign elig = mask_eff ? '0 : (pend & en);
  assign any  = |elig;
  assign idx  = lowest_set(elig);

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (pend[idx] && en[idx] && !mask_eff)); // R2
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic rti_stb,
  input  logic set_stb,
  input  logic clr_stb,
  output logic mask_q,
  output logic mask_eff
);
  logic saved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      saved_q <= 1'b1;
    end else if (enter) begin
      saved_q <= mask_q;
      mask_q  <= 1'b1;
    end else if (rti_stb) begin
      mask_q  <= saved_q;
    end else if (set_stb) begin
      mask_q  <= 1'b1;
    end else if (clr_stb) begin
      mask_q  <= 1'b0;
    end
  end

  assign mask_eff = rti_stb ? saved_q : mask_q;

  AST_RTI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rti_stb && !enter |=> mask_q == $past(saved_q)); // R7
  AST_MASK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb && !enter && !rti_stb |=> mask_q); // R10
endmodule

// File: rtl/irq_boundary_arb.sv
module irq_boundary_arb #(
  parameter int NUM_IRQ = 8,
  localparam int VEC_W  = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               instr_done,
  input  logic               swi_req,
  input  logic               entry_ack,
  input  logic               rti_stb,
  input  logic               mask_set,
  input  logic               mask_clr,
  output logic               win_valid,
  output logic [VEC_W-1:0]   win_vec,
  output logic               mask_bit,
  output logic [NUM_IRQ-1:0] pending
);
  import irq_arb_pkg::*;

  localparam logic [VEC_W-1:0] SWI_ID = VEC_W'(NUM_IRQ);

  win_src_e         win_src;
  logic             mask_eff;
  logic             pick_any;
  logic [VEC_W-1:0] pick_idx;

  // named internal events
  logic arb_event, take_swi, decide, enter, drop, clr_hw;

  assign arb_event = instr_done | rti_stb;
  assign take_swi  = instr_done & swi_req;
  assign decide    = arb_event & ~win_valid & (take_swi | pick_any);
  assign enter     = entry_ack & win_valid;
  assign drop      = mask_clr & win_valid & (win_src == WSRC_HW) & ~entry_ack;
  assign clr_hw    = enter & (win_src == WSRC_HW);

  irq_pend_bank #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (irq_req),
    .clr_stb (clr_hw),
    .clr_idx (win_vec),
    .pend_q  (pending)
  );

  irq_mask_ctl u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (enter),
    .rti_stb  (rti_stb),
    .set_stb  (mask_set),
    .clr_stb  (mask_clr),
    .mask_q   (mask_bit),
    .mask_eff (mask_eff)
  );

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pending),
    .en       (irq_en),
    .mask_eff (mask_eff),
    .any      (pick_any),
    .idx      (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_vec   <= '0;
      win_src   <= WSRC_NONE;
    end else if (enter || drop) begin
      win_valid <= 1'b0;
      win_src   <= WSRC_NONE;
    end else if (decide) begin
      win_valid <= 1'b1;
      win_vec   <= take_swi ? SWI_ID : pick_idx;
      win_src   <= take_swi ? WSRC_SWI : WSRC_HW;
    end
  end

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid && !arb_event |=> !win_valid); // R1
  AST_HW_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !take_swi |-> !mask_eff && irq_en[pick_idx]); // R2
  AST_SWI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_swi && !win_valid |=> win_valid && win_vec == SWI_ID); // R4
  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !entry_ack && !drop |=> win_valid && $stable(win_vec)); // R5
  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> mask_bit && !win_valid); // R6
endmodule

// File: tb/irq_boundary_arb_tb.sv
`timescale 1ns/1ps
module irq_boundary_arb_tb;
  localparam int N = 8;
  localparam int SWI = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_req, irq_en;
  logic         instr_done, swi_req, entry_ack, rti_stb, mask_set, mask_clr;
  logic         win_valid, mask_bit;
  logic [3:0]   win_vec;
  logic [N-1:0] pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  irq_boundary_arb #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .instr_done(instr_done), .swi_req(swi_req), .entry_ack(entry_ack),
    .rti_stb(rti_stb), .mask_set(mask_set), .mask_clr(mask_clr),
    .win_valid(win_valid), .win_vec(win_vec), .mask_bit(mask_bit),
    .pending(pending)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // apply strobes for one clock edge; returns at the next falling edge
  task automatic step(input logic [N-1:0] rq, input logic d, input logic s,
                      input logic a, input logic r, input logic st, input logic cl);
    irq_req = rq; instr_done = d; swi_req = s; entry_ack = a;
    rti_stb = r; mask_set = st; mask_clr = cl;
    @(negedge clk);
    irq_req = '0; instr_done = 0; swi_req = 0; entry_ack = 0;
    rti_stb = 0; mask_set = 0; mask_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9", "mask after reset", mask_bit, 1);
    chk("R9", "pending after reset", pending, 0);
    chk("R9", "valid after reset", win_valid, 0);
  endtask

  task automatic t_basic;
    step('0, 0, 0, 0, 0, 0, 1);
    chk("R10", "mask after clear", mask_bit, 0);
    step(8'h20, 0, 0, 0, 0, 0, 0);
    idle(3);
    chk("R8", "pulse held pending", pending, 8'h20);
    chk("R1", "no winner without boundary", win_valid, 0);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R1", "winner at boundary", win_valid, 1);
    chk("R3", "vector of lone request", win_vec, 5);
    step('0, 0, 0, 1, 0, 0, 0);
    chk("R6", "valid after entry", win_valid, 0);
    chk("R6", "mask after entry", mask_bit, 1);
    chk("R6", "pending after entry", pending, 0);
    step('0, 0, 0, 0, 1, 0, 0);
    chk("R7", "mask restored", mask_bit, 0);
    chk("R7", "no winner when nothing pending", win_valid, 0);
  endtask

  task automatic t_priority;
    step(8'h44, 0, 0, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R3", "lowest index wins", win_vec, 2);
    step('0, 0, 0, 1, 0, 0, 0);
    chk("R6", "only winner cleared", pending, 8'h40);
    step('0, 0, 0, 0, 1, 0, 0);
    chk("R7", "pending taken on return", win_valid, 1);
    chk("R7", "vector taken on return", win_vec, 6);
    step('0, 0, 0, 1, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_masked;
    step('0, 0, 0, 0, 0, 1, 0);
    chk("R10", "mask after set", mask_bit, 1);
    step(8'h10, 0, 0, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R2", "masked request ignored", win_valid, 0);
    irq_en = 8'hEF;
    step('0, 0, 0, 0, 0, 0, 1);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R2", "disabled request ignored", win_valid, 0);
    irq_en = 8'hFF;
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R2", "enabled unmasked taken", win_vec, 4);
    step('0, 0, 0, 1, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_swi;
    step('0, 0, 0, 0, 0, 1, 0);
    step('0, 1, 1, 0, 0, 0, 0);
    chk("R4", "swi while masked valid", win_valid, 1);
    chk("R4", "swi vector", win_vec, SWI);
    step('0, 0, 0, 1, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 0);
    chk("R7", "masked state restored", mask_bit, 1);
    step('0, 0, 0, 0, 0, 0, 1);
    step(8'h01, 0, 0, 0, 0, 0, 0);
    step('0, 1, 1, 0, 0, 0, 0);
    chk("R4", "swi beats index 0", win_vec, SWI);
    step('0, 0, 0, 1, 0, 0, 0);
    chk("R6", "hw flag kept on swi entry", pending, 8'h01);
    step('0, 0, 0, 0, 1, 0, 0);
    chk("R7", "hw taken after swi return", win_vec, 0);
    step('0, 0, 0, 1, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_hold;
    step(8'h08, 0, 0, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R3", "first winner", win_vec, 3);
    step(8'h02, 0, 0, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R5", "winner not displaced", win_vec, 3);
    chk("R5", "winner still valid", win_valid, 1);
    step('0, 0, 0, 0, 0, 0, 1);
    chk("R5", "mask clear drops winner", win_valid, 0);
    step('0, 1, 0, 0, 0, 0, 0);
    chk("R5", "re-arbitrated winner", win_vec, 1);
    step('0, 0, 0, 1, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 0);
    chk("R7", "dropped request taken on return", win_vec, 3);
    step('0, 0, 0, 1, 0, 0, 0);
    step('0, 0, 0, 0, 1, 0, 0);
    chk("R8", "all flags cleared", pending, 0);
  endtask

  initial begin
    rst_n = 0; irq_req = '0; irq_en = '1; instr_done = 0; swi_req = 0;
    entry_ack = 0; rti_stb = 0; mask_set = 0; mask_clr = 0;
    idle(4);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_masked();
    t_swi();
    t_hold();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule